// File: doc/BRIEF.md
# Privilege-Checked Microcode Sequencer

This block is a microprogrammed control unit with a small control store that software can rewrite at run time. On every clock edge it fetches one microinstruction into its instruction register. It expands three encoded fields into one-hot control lines: ALU operation, bus-driver select and register load. Four independent direct bits go straight through. A next-address field and a two-bit branch condition choose the following microaddress.

Each microinstruction also carries an 8-bit access-control field: a minimum privilege level and a mask of required capabilities. Before any line reaches the datapath, the unit compares that field with the current privilege mode and the capability set of the running context. A micro-op the context may not run produces no control activity. It raises a fault and sends the sequencer to a fixed handler address. Rewriting the store therefore cannot bypass protection. Writes to the store are themselves accepted only at the highest privilege level.

Top module: `priv_ucode_ctrl`

## Requirements
- R1: A microinstruction is 30 bits. From MSB to LSB the fields are: minimum privilege [29:28], required capabilities [27:22], ALU code [21:18], bus code [17:15], register-load code [14:11], direct bits [10:7], branch condition [6:5], next address [4:0]. When the current microinstruction is permitted, ALU line k (of 16) and bus line k (of 8) are asserted for field value k, and no other line of that group is asserted.
- R2: For a permitted microinstruction, register-load codes 0 to 11 assert register line k only. Codes 12 to 15 assert no register line and raise `illegalEnc`.
- R3: For a permitted microinstruction, `directOut` equals the direct bits.
- R4: A microinstruction is permitted only when `privMode` (0 = user, 3 = highest) is greater than or equal to its minimum privilege.
- R5: A microinstruction is permitted only when every bit set in its required-capability mask is also set in `ctxCap`.
- R6: A microinstruction that is not permitted drives all ALU, bus, register and direct lines and `illegalEnc` to zero. `fault` is high during that cycle, and the next fetch comes from the fault-handler address (31 by default).
- R7: Branch condition 0 always takes the next-address field. Condition 1 takes it when `zeroFlag` is 1. Condition 2 takes it when `cntNonZero` is 1. Condition 3 never takes it. A branch that is not taken goes to `upc`+1, and 31 wraps to 0.
- R8: A store write (`wrEn`) is performed only when `privMode` is 3. At a lower level the write is discarded, and `fault` is high in that cycle.
- R9: A write to the address that is being fetched at the same clock edge does not reach the fetched microinstruction. The new contents appear from the following fetch of that address onward.
- R10: During reset, and in the first cycle after reset, all control lines, `illegalEnc` and `fault` are 0 and `upc` is 0. The store is cleared to zero, and the first fetch is from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control-store write request |
| wrAddr | input | 5 | Control-store write address |
| wrData | input | 30 | Microinstruction to write |
| privMode | input | 2 | Current privilege mode |
| ctxCap | input | 6 | Capability set of the running context |
| zeroFlag | input | 1 | Datapath zero condition for branches |
| cntNonZero | input | 1 | Loop-counter-nonzero condition for branches |
| aluLines | output | 16 | One-hot ALU operation lines |
| busLines | output | 8 | One-hot bus-driver lines |
| regLines | output | 12 | One-hot register-load lines |
| directOut | output | 4 | Direct control bits |
| illegalEnc | output | 1 | Unused register-load code seen |
| fault | output | 1 | Permission or write-privilege violation |
| upc | output | 5 | Address of the current microinstruction |

## Verification
Two situations are hard to reach from the ports. The first is a denied micro-op held steady long enough to inspect. A denial immediately redirects the sequencer, so the bench parks a self-looping instruction at address 0 at full privilege. It then lowers the privilege or the capabilities only inside the half cycle before the next edge. Within that window it sweeps every capability pattern against every required mask. The second is a write that collides with a fetch of the same address. The bench overwrites the looping instruction in place and watches its old lines survive exactly one more cycle. Branches are reached by steering the loop to a test address and holding the flags there.

// File: rtl/puc_pkg.sv
package puc_pkg;
  localparam int ADDR_W = 5;
  localparam int ALU_W  = 4;
  localparam int BUS_W  = 3;
  localparam int REG_W  = 4;
  localparam int REG_N  = 12;
  localparam int DIR_W  = 4;
  localparam int PRIV_W = 2;
  localparam int CAP_W  = 6;
  localparam int ALU_N  = 1 << ALU_W;
  localparam int BUS_N  = 1 << BUS_W;

  typedef enum logic [1:0] {
    BR_ALWAYS = 2'd0,
    BR_ZERO   = 2'd1,
    BR_CNTNZ  = 2'd2,
    BR_NEVER  = 2'd3
  } branch_e;

  typedef struct packed {
    logic [PRIV_W-1:0] minPriv;
    logic [CAP_W-1:0]  needCap;
    logic [ALU_W-1:0]  aluOp;
    logic [BUS_W-1:0]  busSel;
    logic [REG_W-1:0]  regLd;
    logic [DIR_W-1:0]  direct;
    branch_e           cond;
    logic [ADDR_W-1:0] nextAddr;
  } uinstr_t;

  localparam int UI_W = $bits(uinstr_t);

  // strobes from the sequencer to the decode side
  typedef struct packed {
    logic             fire;
    logic [ALU_W-1:0] aluOp;
    logic [BUS_W-1:0] busSel;
    logic [REG_W-1:0] regLd;
    logic [DIR_W-1:0] direct;
  } strobe_t;
endpackage

// File: rtl/puc_sequencer.sv
module puc_sequencer
  import puc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FAULT_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  uinstr_t           wrData,
  input  logic [PRIV_W-1:0] privMode,
  input  logic [CAP_W-1:0]  ctxCap,
  input  logic              zeroFlag,
  input  logic              cntNonZero,
  output strobe_t           stb,
  output logic              fault,
  output logic [ADDR_W-1:0] upc
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PRIV_W-1:0] TOP_PRIV = '1;

  uinstr_t store [DEPTH];
  uinstr_t mir;
  logic    valid;
  logic    denied;
  logic    wrGrant;
  logic    taken;
  logic [ADDR_W-1:0] nextPc;

  always_comb begin
    denied  = valid && ((privMode < mir.minPriv) || (|(mir.needCap & ~ctxCap)));
    wrGrant = wrEn && (privMode == TOP_PRIV);
    fault   = denied || (wrEn && !wrGrant);
  end

  always_comb begin
    unique case (mir.cond)
      BR_ALWAYS: taken = 1'b1;
      BR_ZERO:   taken = zeroFlag;
      BR_CNTNZ:  taken = cntNonZero;
      default:   taken = 1'b0;
    endcase
  end

  always_comb begin
    if (!valid)      nextPc = '0;
    else if (denied) nextPc = FAULT_ADDR;
    else if (taken)  nextPc = mir.nextAddr;
    else             nextPc = upc + ADDR_W'(1);
  end

  // read-before-write: the fetch at an edge sees the old contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      mir   <= '0;
      upc   <= '0;
      valid <= 1'b0;
    end else begin
      if (wrGrant) store[wrAddr] <= wrData;
      mir   <= store[nextPc];
      upc   <= nextPc;
      valid <= 1'b1;
    end
  end

  always_comb begin
    stb.fire   = valid && !denied;
    stb.aluOp  = mir.aluOp;
    stb.busSel = mir.busSel;
    stb.regLd  = mir.regLd;
    stb.direct = mir.direct;
  end
endmodule

// File: rtl/puc_onehot.sv
module puc_onehot #(
  parameter int CODE_W = 4,
  parameter int LINES  = 16
) (
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic [LINES-1:0]  lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = en && (code == CODE_W'(i));
  end
endmodule

// File: rtl/puc_decode.sv
module puc_decode
  import puc_pkg::*;
(
  input  strobe_t          stb,
  output logic [ALU_N-1:0] aluLines,
  output logic [BUS_N-1:0] busLines,
  output logic [REG_N-1:0] regLines,
  output logic [DIR_W-1:0] directOut,
  output logic             illegalEnc
);
  puc_onehot #(.CODE_W(ALU_W), .LINES(ALU_N)) u_alu (
    .code(stb.aluOp), .en(stb.fire), .lines(aluLines));
  puc_onehot #(.CODE_W(BUS_W), .LINES(BUS_N)) u_bus (
    .code(stb.busSel), .en(stb.fire), .lines(busLines));
  // codes at or above REG_N match no line
  puc_onehot #(.CODE_W(REG_W), .LINES(REG_N)) u_reg (
    .code(stb.regLd), .en(stb.fire), .lines(regLines));

  assign illegalEnc = stb.fire && (stb.regLd >= REG_W'(REG_N));
  assign directOut  = stb.fire ? stb.direct : '0;
endmodule

// File: rtl/priv_ucode_ctrl.sv
module priv_ucode_ctrl
  import puc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FAULT_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [UI_W-1:0]   wrData,
  input  logic [PRIV_W-1:0] privMode,
  input  logic [CAP_W-1:0]  ctxCap,
  input  logic              zeroFlag,
  input  logic              cntNonZero,
  output logic [ALU_N-1:0]  aluLines,
  output logic [BUS_N-1:0]  busLines,
  output logic [REG_N-1:0]  regLines,
  output logic [DIR_W-1:0]  directOut,
  output logic              illegalEnc,
  output logic              fault,
  output logic [ADDR_W-1:0] upc
);
  strobe_t stb;

  puc_sequencer #(.FAULT_ADDR(FAULT_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(uinstr_t'(wrData)), .privMode(privMode), .ctxCap(ctxCap),
    .zeroFlag(zeroFlag), .cntNonZero(cntNonZero),
    .stb(stb), .fault(fault), .upc(upc));

  puc_decode u_dec (
    .stb(stb), .aluLines(aluLines), .busLines(busLines),
    .regLines(regLines), .directOut(directOut), .illegalEnc(illegalEnc));
endmodule

// File: rtl/priv_ucode_ctrl_chk.sv
module priv_ucode_ctrl_chk
  import puc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FAULT_ADDR = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [PRIV_W-1:0] privMode,
  input logic [ALU_N-1:0]  aluLines,
  input logic [BUS_N-1:0]  busLines,
  input logic [REG_N-1:0]  regLines,
  input logic [DIR_W-1:0]  directOut,
  input logic              illegalEnc,
  input logic              fault,
  input logic [ADDR_W-1:0] upc
);
  logic badWrite;
  logic execDeny;
  assign badWrite = wrEn && (privMode != '1);
  assign execDeny = fault && !badWrite;

  AST_GROUPS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (aluLines != '0) |-> ($countones(aluLines) == 1 && $countones(busLines) == 1)); // R1
  AST_ILLEGAL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    illegalEnc |-> (regLines == '0 && aluLines != '0)); // R2
  AST_DIRECT_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (directOut != '0) |-> (aluLines != '0)); // R3
  AST_DENY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    execDeny |-> (aluLines == '0 && busLines == '0 && regLines == '0 && directOut == '0 && !illegalEnc)); // R6
  AST_DENY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    execDeny |=> (upc == FAULT_ADDR)); // R6
  AST_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    badWrite |-> fault); // R8
endmodule

bind priv_ucode_ctrl priv_ucode_ctrl_chk #(.FAULT_ADDR(FAULT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .privMode(privMode),
  .aluLines(aluLines), .busLines(busLines), .regLines(regLines),
  .directOut(directOut), .illegalEnc(illegalEnc), .fault(fault), .upc(upc));

// File: tb/tb_priv_ucode_ctrl.sv
`timescale 1ns/1ps
module tb_priv_ucode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [29:0] wrData = '0;
  logic [1:0]  privMode = 2'd3;
  logic [5:0]  ctxCap = '1;
  logic        zeroFlag = 1'b0;
  logic        cntNonZero = 1'b0;
  logic [15:0] aluLines;
  logic [7:0]  busLines;
  logic [11:0] regLines;
  logic [3:0]  directOut;
  logic        illegalEnc;
  logic        fault;
  logic [4:0]  upc;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  priv_ucode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .privMode(privMode), .ctxCap(ctxCap), .zeroFlag(zeroFlag),
    .cntNonZero(cntNonZero), .aluLines(aluLines), .busLines(busLines),
    .regLines(regLines), .directOut(directOut), .illegalEnc(illegalEnc),
    .fault(fault), .upc(upc));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] mk(input logic [1:0] mp, input logic [5:0] cap,
      input logic [3:0] alu, input logic [2:0] bus, input logic [3:0] rg,
      input logic [3:0] dir, input logic [1:0] cond, input logic [4:0] nxt);
    return {mp, cap, alu, bus, rg, dir, cond, nxt};
  endfunction

  task automatic writeStore(input logic [4:0] a, input logic [29:0] d);
    @(negedge clk);
    privMode = 2'd3; ctxCap = '1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // place ins at address 0 and wait until it is the current microinstruction
  task automatic runInstr(input logic [29:0] ins);
    writeStore(5'd0, ins);
    @(negedge clk);
    for (int n = 0; n < 40 && upc != 5'd0; n++) @(negedge clk);
  endtask

  task automatic waitUpc(input logic [4:0] a);
    for (int n = 0; n < 40 && upc != a; n++) @(negedge clk);
  endtask

  task automatic branchCase(input logic [1:0] cond, input logic zf, input logic cz,
                            input logic [4:0] expPc);
    zeroFlag = zf; cntNonZero = cz;
    writeStore(5'd5, mk(2'd0, 6'd0, 4'd1, 3'd0, 4'd0, 4'd0, cond, 5'd9));
    writeStore(5'd0, mk(2'd0, 6'd0, 4'd0, 3'd0, 4'd0, 4'd0, 2'd0, 5'd5));
    @(negedge clk); @(negedge clk);
    waitUpc(5'd5);
    @(negedge clk);
    check(upc == expPc, $sformatf("R7 cond=%0d zf=%0d cnz=%0d", cond, zf, cz), upc, expPc);
  endtask

  initial begin
    // R10 reset state
    #2;
    check({aluLines, busLines, regLines, directOut, illegalEnc, fault} == '0,
          "R10 outputs in reset", {aluLines, busLines}, 0);
    check(upc == 5'd0, "R10 upc in reset", upc, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check({aluLines, busLines, regLines, fault} == '0, "R10 first cycle idle",
          aluLines, 0);
    @(negedge clk);
    check(aluLines == 16'd1 && busLines == 8'd1 && regLines == 12'd1 && upc == 5'd0,
          "R10 first fetch of cleared address 0", aluLines, 1);

    // R1 R2 R3 sweep of all field codes
    for (int c = 0; c < 16; c++) begin
      runInstr(mk(2'd0, 6'd0, 4'(c), 3'(c % 8), 4'(c), 4'(c), 2'd0, 5'd0));
      privMode = 2'd0; ctxCap = '0;
      #1;
      check(aluLines == 16'(1 << c), "R1 alu line", aluLines, 1 << c);
      check(busLines == 8'(1 << (c % 8)), "R1 bus line", busLines, 1 << (c % 8));
      check(regLines == ((c < 12) ? 12'(1 << c) : 12'd0), "R2 register line", regLines,
            (c < 12) ? (1 << c) : 0);
      check(illegalEnc == (c >= 12), "R2 illegal flag", illegalEnc, c >= 12);
      check(directOut == 4'(c), "R3 direct bits", directOut, c);
      check(fault == 1'b0, "R4 user-level op grants", fault, 0);
    end

    // R4 privilege sweep
    for (int mp = 0; mp < 4; mp++) begin
      runInstr(mk(2'(mp), 6'd0, 4'd3, 3'd2, 4'd12, 4'hF, 2'd0, 5'd0));
      for (int pm = 0; pm < 4; pm++) begin
        privMode = 2'(pm);
        #0.2;
        check(fault == (pm < mp), "R4 fault vs privilege", fault, pm < mp);
        check({aluLines, busLines, regLines, directOut, illegalEnc} ==
              ((pm >= mp) ? {16'd8, 8'd4, 12'd0, 4'hF, 1'b1} : 41'd0),
              "R6 lines gated by privilege", aluLines, (pm >= mp) ? 8 : 0);
      end
    end
    // R6 fault vector
    runInstr(mk(2'd3, 6'd0, 4'd5, 3'd0, 4'd0, 4'd0, 2'd0, 5'd0));
    privMode = 2'd0;
    #1;
    check(fault == 1'b1 && aluLines == '0, "R6 denied cycle", {fault, aluLines}, 32'h10000);
    @(negedge clk);
    check(upc == 5'd31, "R6 next fetch at handler", upc, 31);

    // R5 capability sweep
    for (int need = 0; need < 64; need++) begin
      runInstr(mk(2'd0, 6'(need), 4'd6, 3'd0, 4'd0, 4'd0, 2'd0, 5'd0));
      privMode = 2'd3;
      for (int cx = 0; cx < 64; cx++) begin
        ctxCap = 6'(cx);
        #0.05;
        check({fault, aluLines != '0} ==
              (((need & ~cx) == 0) ? 2'b01 : 2'b10),
              $sformatf("R5 need=%0h ctx=%0h", need, cx), {fault, aluLines != '0},
              ((need & ~cx) == 0) ? 1 : 2);
      end
      ctxCap = '1;
    end

    // R9 write colliding with fetch of the same address
    runInstr(mk(2'd0, 6'd0, 4'd2, 3'd0, 4'd0, 4'd0, 2'd0, 5'd0));
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd0; privMode = 2'd3; ctxCap = '1;
    wrData = mk(2'd0, 6'd0, 4'd7, 3'd0, 4'd0, 4'd0, 2'd0, 5'd0);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check(aluLines == 16'd4 && upc == 5'd0, "R9 old contents fetched at write edge",
          aluLines, 4);
    @(negedge clk);
    #1;
    check(aluLines == 16'd128, "R9 new contents on next fetch", aluLines, 128);

    // R8 write at lower privilege is dropped
    @(negedge clk);
    privMode = 2'd1; wrEn = 1'b1; wrAddr = 5'd0;
    wrData = mk(2'd0, 6'd0, 4'd9, 3'd0, 4'd0, 4'd0, 2'd0, 5'd0);
    #1;
    check(fault == 1'b1, "R8 fault on low-privilege write", fault, 1);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check(fault == 1'b0, "R8 no fault without write", fault, 0);
    @(negedge clk); @(negedge clk);
    #1;
    check(aluLines == 16'd128, "R8 store unchanged after dropped write", aluLines, 128);

    // R7 branching
    branchCase(2'd0, 1'b0, 1'b0, 5'd9);
    branchCase(2'd1, 1'b1, 1'b0, 5'd9);
    branchCase(2'd1, 1'b0, 1'b1, 5'd6);
    branchCase(2'd2, 1'b0, 1'b1, 5'd9);
    branchCase(2'd2, 1'b1, 1'b0, 5'd6);
    branchCase(2'd3, 1'b1, 1'b1, 5'd6);
    writeStore(5'd31, mk(2'd0, 6'd0, 4'd0, 3'd0, 4'd0, 4'd0, 2'd3, 5'd17));
    writeStore(5'd0, mk(2'd0, 6'd0, 4'd0, 3'd0, 4'd0, 4'd0, 2'd0, 5'd31));
    @(negedge clk); @(negedge clk);
    waitUpc(5'd31);
    @(negedge clk);
    check(upc == 5'd0, "R7 increment wraps 31 to 0", upc, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule